// File: doc/BRIEF.md
# Banked Stack Pointer Unit with Status Aliasing

This unit holds the two stack pointers of a small CPU core: a 64-bit user stack pointer and a 48-bit supervisor stack pointer. The floating-point status flags live in the upper 16 bits of the user stack pointer. There is exactly one copy of these flags, and it always stays with the user pointer. The register file reaches this state through three register specifiers: the stack pointer, the supervisor stack pointer and the status register.

Interrupt entry does not copy any data. It sets a single swap flag, and that flag changes how the two pointer specifiers map onto the physical storage. A return strobe clears the flag. While the flag is set, the core is inside a service routine. During that time, updates to the floating-point flags are dropped, so the flags seen by user code survive the interrupt.

Reads are combinational from the current state. Writes, flag accumulation and swap changes all take effect at the next rising clock edge.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset, in_isr_o is 0, and the user pointer, the supervisor pointer and the status flags are all zero.
- R2: Specifier encoding is 0 = stack pointer, 1 = supervisor stack pointer, 2 = status register. Specifier 3 reads as zero, and a write to it changes nothing.
- R3: irq_enter_i sets the swap flag and irq_return_i clears it. When both arrive in the same cycle, entry wins. in_isr_o shows the flag.
- R4: With the flag clear, specifier 0 reaches the user pointer and specifier 1 reaches the supervisor pointer. With the flag set, the mapping is reversed. The user pointer reads as {flags[15:0], pointer[47:0]}. Swapping never alters the stored values.
- R5: The supervisor pointer keeps only bits 47:0 of a write. Reads of it return zero in bits 63:48.
- R6: Specifier 2 reads as {48'b0, flags}, whatever the swap flag is. A write to specifier 2 replaces the flags with wr_data_i[15:0] and leaves both pointers unchanged.
- R7: A pointer write that maps to the user pointer changes only bits 47:0. The flags in bits 63:48 are kept.
- R8: When fpu_vld_i is 1 and the core is not in a service routine, fpu_flags_i is ORed into the flags. Flags already set stay set.
- R9: While in a service routine, fpu_vld_i has no effect on the flags.
- R10: A write to specifier 2 takes priority over a flag accumulate in the same cycle. The flags become exactly the written value.
- R11: A write or accumulate in the same cycle as irq_enter_i or irq_return_i uses the mapping and routine state that held before that edge.
- R12: Reads are combinational. Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_i | input | 2 | Read specifier |
| rd_data_o | output | 64 | Read data |
| wr_en_i | input | 1 | Write enable |
| wr_sel_i | input | 2 | Write specifier |
| wr_data_i | input | 64 | Write data |
| fpu_vld_i | input | 1 | Flag accumulate valid |
| fpu_flags_i | input | 16 | Flag bits to accumulate |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| irq_return_i | input | 1 | Return-from-interrupt strobe |
| in_isr_o | output | 1 | Service-routine status (swap flag) |

## Verification
A wrong swap flag shows up on in_isr_o in the same cycle. Any read through specifier 0 or 1 then returns the other pointer, immediately. A corrupted flag field is visible at once on specifier 2, and it also appears in bits 63:48 of whichever specifier maps to the user pointer. A pointer write that leaks into the flags, or an accumulate that slips through during a routine, can be seen one cycle after the offending edge.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  parameter int unsigned XLEN  = 64;
  parameter int unsigned PTR_W = 48;

  typedef enum logic [1:0] {
    SEL_SP   = 2'd0,
    SEL_SSP  = 2'd1,
    SEL_FPSR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sp_bank_map.sv
// Rename decode: specifier + swap flag -> physical target
module sp_bank_map
  import sp_bank_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       swap_i,
  output logic       user_o,
  output logic       supv_o,
  output logic       stat_o
);
  logic is_sp, is_ssp;

  assign is_sp  = (sel_i == SEL_SP);
  assign is_ssp = (sel_i == SEL_SSP);
  assign user_o = (is_sp & ~swap_i) | (is_ssp & swap_i);
  assign supv_o = (is_sp & swap_i) | (is_ssp & ~swap_i);
  assign stat_o = (sel_i == SEL_FPSR);
endmodule

// File: rtl/sp_bank_ptrs.sv
module sp_bank_ptrs #(
  parameter int unsigned PTR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             usr_we_i,
  input  logic             supv_we_i,
  input  logic [PTR_W-1:0] data_i,
  output logic [PTR_W-1:0] usr_ptr_o,
  output logic [PTR_W-1:0] supv_ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_ptr_o  <= '0;
      supv_ptr_o <= '0;
    end else begin
      if (usr_we_i)  usr_ptr_o  <= data_i;
      if (supv_we_i) supv_ptr_o <= data_i;
    end
  end
endmodule

// File: rtl/sp_bank_fpsr.sv
module sp_bank_fpsr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         acc_en_i,
  input  logic [W-1:0] acc_flags_i,
  output logic [W-1:0] fpsr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fpsr_o <= '0;
    else if (wr_en_i)  fpsr_o <= wr_data_i;              // explicit write wins
    else if (acc_en_i) fpsr_o <= fpsr_o | acc_flags_i;   // sticky
  end
endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
  import sp_bank_pkg::*;
#(
  parameter int unsigned XLEN_P  = XLEN,
  parameter int unsigned PTR_W_P = PTR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 rd_sel_i,
  output logic [XLEN_P-1:0]          rd_data_o,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_sel_i,
  input  logic [XLEN_P-1:0]          wr_data_i,
  input  logic                       fpu_vld_i,
  input  logic [XLEN_P-PTR_W_P-1:0]  fpu_flags_i,
  input  logic                       irq_enter_i,
  input  logic                       irq_return_i,
  output logic                       in_isr_o
);
  localparam int unsigned FPSR_W = XLEN_P - PTR_W_P;

  logic              swap_q;
  logic              rd_user, rd_supv, rd_stat;
  logic              wr_user, wr_supv, wr_stat;
  logic [PTR_W_P-1:0] usr_ptr, supv_ptr;
  logic [FPSR_W-1:0]  fpsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           swap_q <= 1'b0;
    else if (irq_enter_i)  swap_q <= 1'b1;
    else if (irq_return_i) swap_q <= 1'b0;
  end
  assign in_isr_o = swap_q;

  sp_bank_map u_rd_map (
    .sel_i (rd_sel_i), .swap_i(swap_q),
    .user_o(rd_user),  .supv_o(rd_supv), .stat_o(rd_stat)
  );

  sp_bank_map u_wr_map (
    .sel_i (wr_sel_i), .swap_i(swap_q),
    .user_o(wr_user),  .supv_o(wr_supv), .stat_o(wr_stat)
  );

  sp_bank_ptrs #(.PTR_W(PTR_W_P)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .usr_we_i  (wr_en_i & wr_user),
    .supv_we_i (wr_en_i & wr_supv),
    .data_i    (wr_data_i[PTR_W_P-1:0]),
    .usr_ptr_o (usr_ptr),
    .supv_ptr_o(supv_ptr)
  );

  sp_bank_fpsr #(.W(FPSR_W)) u_fpsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i & wr_stat),
    .wr_data_i  (wr_data_i[FPSR_W-1:0]),
    .acc_en_i   (fpu_vld_i & ~swap_q),
    .acc_flags_i(fpu_flags_i),
    .fpsr_o     (fpsr_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_user)      rd_data_o = {fpsr_q, usr_ptr};
    else if (rd_supv) rd_data_o = {{FPSR_W{1'b0}}, supv_ptr};
    else if (rd_stat) rd_data_o = {{PTR_W_P{1'b0}}, fpsr_q};
  end
endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
  parameter int unsigned XLEN_P  = 64,
  parameter int unsigned PTR_W_P = 48
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                rd_sel_i,
  input logic [XLEN_P-1:0]         rd_data_o,
  input logic                      wr_en_i,
  input logic [1:0]                wr_sel_i,
  input logic [XLEN_P-1:0]         wr_data_i,
  input logic                      fpu_vld_i,
  input logic [XLEN_P-PTR_W_P-1:0] fpu_flags_i,
  input logic                      irq_enter_i,
  input logic                      irq_return_i,
  input logic                      in_isr_o,
  input logic [XLEN_P-PTR_W_P-1:0] fpsr_q
);
  localparam int unsigned FPSR_W = XLEN_P - PTR_W_P;

  logic stat_wr;
  assign stat_wr = wr_en_i && (wr_sel_i == 2'd2);

  AST_ENTER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_enter_i |=> in_isr_o);                                            // R3
  AST_RETURN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_return_i && !irq_enter_i |=> !in_isr_o);                         // R3
  AST_SUPV_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_sel_i == 2'd1 && !in_isr_o) || (rd_sel_i == 2'd0 && in_isr_o))
      |-> rd_data_o[XLEN_P-1:PTR_W_P] == '0);                             // R5
  AST_STAT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> fpsr_q == $past(wr_data_i[FPSR_W-1:0]));                  // R10
  AST_ISR_FLAGS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_isr_o && !stat_wr |=> $stable(fpsr_q));                            // R9
  AST_PTR_WRITE_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !stat_wr && !(fpu_vld_i && !in_isr_o) |=> $stable(fpsr_q)); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpu_vld_i && !in_isr_o && !stat_wr
      |=> (fpsr_q & $past(fpu_flags_i)) == $past(fpu_flags_i));           // R8
endmodule

bind sp_bank_unit sp_bank_chk #(.XLEN_P(XLEN_P), .PTR_W_P(PTR_W_P)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .fpu_vld_i(fpu_vld_i), .fpu_flags_i(fpu_flags_i), .irq_enter_i(irq_enter_i),
  .irq_return_i(irq_return_i), .in_isr_o(in_isr_o), .fpsr_q(fpsr_q)
);

// File: tb/sim_sp_bank_unit.sv
`timescale 1ns/1ps
module sim_sp_bank_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        fpu_vld_i = 1'b0;
  logic [15:0] fpu_flags_i = '0;
  logic        irq_enter_i = 1'b0;
  logic        irq_return_i = 1'b0;
  logic        in_isr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_isr;
  logic [47:0] m_uptr, m_sptr;
  logic [15:0] m_flags;

  always #2 clk_i = ~clk_i;

  sp_bank_unit u0 (.*);

  function automatic logic [63:0] exp_read(input logic [1:0] sel);
    bit to_user;
    if (sel == 2'd2) return {48'h0, m_flags};
    if (sel == 2'd3) return 64'h0;
    to_user = (sel == 2'd0) ? !m_isr : m_isr;
    return to_user ? {m_flags, m_uptr} : {16'h0, m_sptr};
  endfunction

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] rs, input logic we, input logic [1:0] ws,
                       input logic [63:0] wd, input logic vld, input logic [15:0] fl,
                       input logic ent, input logic ret);
    rd_sel_i = rs; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
    fpu_vld_i = vld; fpu_flags_i = fl; irq_enter_i = ent; irq_return_i = ret;
  endtask

  // compare present state, advance model, cross one clock
  task automatic cyc(input string tag);
    bit to_user;
    #1;
    chk64(tag, rd_data_o, exp_read(rd_sel_i));
    chk64(tag, {63'h0, in_isr_o}, {63'h0, m_isr});
    if (wr_en_i && wr_sel_i < 2) begin
      to_user = (wr_sel_i == 2'd0) ? !m_isr : m_isr;
      if (to_user) m_uptr = wr_data_i[47:0];
      else         m_sptr = wr_data_i[47:0];
    end
    if (wr_en_i && wr_sel_i == 2'd2) m_flags = wr_data_i[15:0];
    else if (fpu_vld_i && !m_isr)    m_flags = m_flags | fpu_flags_i;
    if (irq_enter_i)       m_isr = 1;
    else if (irq_return_i) m_isr = 0;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_read(input logic [1:0] rs, input string tag);
    drive(rs, 0, 0, 0, 0, 0, 0, 0);
    cyc(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_isr = 0; m_uptr = 0; m_sptr = 0; m_flags = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    idle_read(2'd0, "R1"); idle_read(2'd1, "R1"); idle_read(2'd2, "R1");
    // R7 pointer write keeps flags
    drive(0, 1, 0, 64'hAAAA_1234_5678_9ABC, 0, 0, 0, 0); cyc("R7");
    idle_read(2'd0, "R7"); idle_read(2'd2, "R7");
    // R6 status write
    drive(2, 1, 2, 64'hDEAD_BEEF_CAFE_0A05, 0, 0, 0, 0); cyc("R6");
    idle_read(2'd2, "R6"); idle_read(2'd0, "R6");
    // R8 sticky accumulate
    drive(2, 0, 0, 0, 1, 16'h0010, 0, 0); cyc("R8");
    drive(2, 0, 0, 0, 1, 16'h0001, 0, 0); cyc("R8");
    idle_read(2'd2, "R8");
    // R5 supervisor pointer width
    drive(1, 1, 1, 64'hFFFF_0000_0000_1000, 0, 0, 0, 0); cyc("R5");
    idle_read(2'd1, "R5");
    // R11 entry with write and accumulate in same cycle
    drive(0, 1, 0, 64'h0000_0000_0000_2000, 1, 16'h0100, 1, 0); cyc("R11");
    idle_read(2'd1, "R11"); idle_read(2'd2, "R11");
    // R4 swapped mapping
    idle_read(2'd0, "R4"); idle_read(2'd1, "R4");
    // R9 accumulate ignored in routine
    drive(2, 0, 0, 0, 1, 16'h8000, 0, 0); cyc("R9");
    idle_read(2'd2, "R9"); idle_read(2'd1, "R9");
    // R4 write to SP in routine reaches supervisor pointer
    drive(0, 1, 0, 64'h1234_0000_0000_3000, 0, 0, 0, 0); cyc("R4");
    idle_read(2'd0, "R4"); idle_read(2'd1, "R4");
    // R3 both strobes: entry wins
    drive(0, 0, 0, 0, 0, 0, 1, 1); cyc("R3");
    idle_read(2'd0, "R3");
    // R11 return with write in same cycle uses pre-return mapping
    drive(0, 1, 0, 64'h0000_0000_0000_4000, 0, 0, 0, 1); cyc("R11");
    idle_read(2'd1, "R11"); idle_read(2'd0, "R11");
    // R10 status write beats accumulate
    drive(2, 1, 2, 64'h0000_0000_0000_1111, 1, 16'h2222, 0, 0); cyc("R10");
    idle_read(2'd2, "R10");
    // R2 specifier 3 reads zero, write ignored
    drive(3, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0); cyc("R2");
    idle_read(2'd0, "R2"); idle_read(2'd1, "R2"); idle_read(2'd2, "R2"); idle_read(2'd3, "R2");
    // R12 randomized traffic against the model
    for (int i = 0; i < 4000; i++) begin
      drive($urandom_range(0, 3), ($urandom_range(0, 2) == 0), $urandom_range(0, 3),
            {$urandom, $urandom}, $urandom_range(0, 1), 16'($urandom),
            ($urandom_range(0, 15) == 0), ($urandom_range(0, 11) == 0));
      cyc("R12");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule